// File: doc/BRIEF.md
# Stereo Serial Audio Word Receiver

This block receives the three-wire serial audio stream and turns it into parallel samples. Data and word select are sampled on each rising edge of the bit clock. A word-select level selects the channel: low is left and high is right. The word-select line toggles one bit before the MSB of each new word. The bit sampled at the edge where the toggle is first seen is therefore the last bit of the word that is ending.

The receiver has a fixed width. The first bit after a toggle always goes into the MSB position, and each following bit goes one place lower. If a word is longer than the receiver, the extra low bits are dropped. If it is shorter, the unfilled low bits read as zero. At each toggle the collected word is copied into the left or right output register, a one-cycle strobe marks the copy, and the bit store is cleared for the next word.

A parameter chooses how the bit position is tracked: a walking one-hot token or a binary counter with a decoder. Both give the same port behaviour.

Top module: `stereo_word_rx`

## Requirements
- R1: While reset is low, and after it is released, both output words are zero and both strobes are low until a word is accepted.
- R2: Data is taken MSB first on rising bit-clock edges: a word of exactly WIDTH bits appears in its output register unchanged.
- R3: A word is transferred on the rising edge where the sampled word select differs from the previous sample. That edge's data bit is the word's last bit. The destination is left if word select was 0 during the word and right if it was 1.
- R4: Each transfer raises only the matching strobe (left_valid or right_valid) for exactly one cycle. The other channel's output register keeps its value.
- R5: A word longer than WIDTH bits is truncated: only its first WIDTH bits are kept, and the remaining bits have no effect.
- R6: A word shorter than WIDTH bits is left-aligned with zero low bits, even when it follows a longer word.
- R7: The word that ends at the first word-select change after reset is discarded: no strobe, and the output registers are unchanged.
- R8: At most one bit position is enabled at a time. The token and counter variants (USE_TOKEN = 1 or 0) produce identical outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all capture on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select: 0 left, 1 right |
| sd | input | 1 | Serial data, MSB first |
| left_word | output | WIDTH | Last accepted left sample |
| right_word | output | WIDTH | Last accepted right sample |
| left_valid | output | 1 | One-cycle strobe on a left update |
| right_valid | output | 1 | One-cycle strobe on a right update |

## Verification
A wrong bit position shows up at the very next transfer as a word shifted or scrambled against the expected left-aligned value. This is why words of every length around WIDTH are compared exactly. A bit store that is not cleared shows up only when a short word follows a long one, as stale ones in the low bits, so that ordering is exercised. Channel or strobe mistakes appear in the cycle after the word-select change, as a wrong strobe or a disturbed opposite register. The counter variant runs in parallel with the token variant and is compared with it at every transfer.

// File: rtl/stereo_word_rx.sv
module stereo_word_rx #(
  parameter int WIDTH     = 16,
  parameter bit USE_TOKEN = 1'b1
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             ws,
  input  logic             sd,
  output logic [WIDTH-1:0] left_word,
  output logic [WIDTH-1:0] right_word,
  output logic             left_valid,
  output logic             right_valid
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic             ws_q, live, armed;
  logic [WIDTH-1:0] bits_q, bits_d, bit_en;
  logic             chg;

  assign chg    = live & (ws ^ ws_q);
  assign bits_d = (bits_q & ~bit_en) | ({WIDTH{sd}} & bit_en);

  generate
    if (USE_TOKEN) begin : g_token
      logic [WIDTH-1:0] tok;
      always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)   tok <= '0;
        else if (chg) tok <= MSB_ONLY;
        else          tok <= tok >> 1;
      end
      assign bit_en = tok;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)                   cnt <= CW'(WIDTH);
        else if (chg)                 cnt <= '0;
        else if (cnt != CW'(WIDTH))   cnt <= cnt + 1'b1;
      end
      assign bit_en = (cnt < CW'(WIDTH)) ? (MSB_ONLY >> cnt) : '0;
    end
  endgenerate

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q        <= 1'b0;
      live        <= 1'b0;
      armed       <= 1'b0;
      bits_q      <= '0;
      left_word   <= '0;
      right_word  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
    end else begin
      live        <= 1'b1;
      ws_q        <= ws;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      if (chg) begin
        bits_q <= '0;
        armed  <= 1'b1;
        if (armed) begin
          if (ws_q) begin
            right_word  <= bits_d;
            right_valid <= 1'b1;
          end else begin
            left_word  <= bits_d;
            left_valid <= 1'b1;
          end
        end
      end else begin
        bits_q <= bits_d;
      end
    end
  end
endmodule

module stereo_word_rx_chk #(
  parameter int WIDTH = 16
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             ws,
  input logic [WIDTH-1:0] left_word,
  input logic [WIDTH-1:0] right_word,
  input logic             left_valid,
  input logic             right_valid,
  input logic [WIDTH-1:0] bit_en
);
  a_r1_reset_quiet: assert property (@(posedge bclk)
    !rst_n |=> (!left_valid && !right_valid));

  a_r4_one_channel: assert property (@(posedge bclk) disable iff (!rst_n)
    !(left_valid && right_valid));

  a_r4_left_single: assert property (@(posedge bclk) disable iff (!rst_n)
    left_valid |=> !left_valid);

  a_r4_right_single: assert property (@(posedge bclk) disable iff (!rst_n)
    right_valid |=> !right_valid);

  a_r4_left_hold: assert property (@(posedge bclk) disable iff (!rst_n)
    !left_valid |-> $stable(left_word));

  a_r4_right_hold: assert property (@(posedge bclk) disable iff (!rst_n)
    !right_valid |-> $stable(right_word));

  a_r3_strobe_on_change: assert property (@(posedge bclk) disable iff (!rst_n)
    (left_valid || right_valid) |-> ($past(ws) != $past(ws, 2)));

  a_r3_left_from_low: assert property (@(posedge bclk) disable iff (!rst_n)
    left_valid |-> ($past(ws, 2) == 1'b0));

  a_r8_single_enable: assert property (@(posedge bclk) disable iff (!rst_n)
    $onehot0(bit_en));
endmodule

bind stereo_word_rx stereo_word_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .ws(ws),
  .left_word(left_word), .right_word(right_word),
  .left_valid(left_valid), .right_valid(right_valid),
  .bit_en(bit_en)
);

// File: tb/stereo_word_rx_bench.sv
module stereo_word_rx_bench;
  localparam int W = 16;
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {6'd16, 32'h0000A5C3},
    {6'd16, 32'h00001234},
    {6'd8,  32'h000000F1},
    {6'd24, 32'h00BEEF12},
    {6'd4,  32'h00000009},
    {6'd20, 32'h0007FFFF},
    {6'd1,  32'h00000001},
    {6'd17, 32'h0001FFFE},
    {6'd15, 32'h00007FFF},
    {6'd16, 32'h00000000}
  };

  logic bclk = 1'b0, rst_n = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [W-1:0] lw, rw, lw2, rw2;
  logic lv, rv, lv2, rv2;
  int checks = 0, fails = 0, lcount = 0, rcount = 0;
  bit done = 0;

  always #2 bclk = ~bclk;

  stereo_word_rx #(.WIDTH(W), .USE_TOKEN(1'b1)) u_stereo_word_rx (
    .bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd),
    .left_word(lw), .right_word(rw), .left_valid(lv), .right_valid(rv));

  stereo_word_rx #(.WIDTH(W), .USE_TOKEN(1'b0)) u_stereo_word_rx_cnt (
    .bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd),
    .left_word(lw2), .right_word(rw2), .left_valid(lv2), .right_valid(rv2));

  always @(negedge bclk) begin
    if (lv) lcount++;
    if (rv) rcount++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] v, input int n, input logic ch, input logic nxt);
    for (int i = 0; i < n; i++) begin
      @(negedge bclk);
      ws = (i == n - 1) ? nxt : ch;
      sd = v[n-1-i];
    end
    @(posedge bclk);
    #1;
  endtask

  function automatic logic [W-1:0] expect_word(input logic [31:0] v, input int n);
    logic [31:0] r;
    if (n >= W) r = v >> (n - W);
    else        r = v << (W - n);
    return r[W-1:0];
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_l, exp_r, e;
    int nl;
    exp_l = '0;
    exp_r = '0;
    nl = 0;
    repeat (3) @(posedge bclk);
    #1;
    chk("R1 reset left_word", lw, 0);
    chk("R1 reset right_word", rw, 0);
    chk("R1 reset strobes", {lv, rv}, 0);
    @(negedge bclk);
    rst_n = 1'b1;
    repeat (3) @(negedge bclk);

    send_word(32'h5, 3, 1'b0, 1'b1);
    chk("R7 first word discarded strobes", {lv, rv}, 0);
    chk("R7 first word discarded left", lw, 0);

    for (int k = 0; k < NV; k++) begin
      logic ch;
      int n;
      logic [31:0] v;
      ch = (k % 2 == 0) ? 1'b1 : 1'b0;
      n = int'(VEC[k][37:32]);
      v = VEC[k][31:0];
      send_word(v, n, ch, ~ch);
      e = expect_word(v, n);
      if (ch) begin
        exp_r = e;
        chk($sformatf("R3 R2 R5 R6 right word %0d", k), rw, exp_r);
        chk($sformatf("R4 right strobe %0d", k), {lv, rv}, 2'b01);
        chk($sformatf("R4 left held %0d", k), lw, exp_l);
      end else begin
        exp_l = e;
        nl++;
        chk($sformatf("R3 R2 R5 R6 left word %0d", k), lw, exp_l);
        chk($sformatf("R4 left strobe %0d", k), {lv, rv}, 2'b10);
        chk($sformatf("R4 right held %0d", k), rw, exp_r);
      end
      chk($sformatf("R8 variants agree %0d", k), {lw2, rw2, lv2, rv2}, {lw, rw, lv, rv});
    end
    @(negedge bclk);
    @(negedge bclk);
    chk("R4 left strobe count", lcount, nl);
    chk("R4 right strobe count", rcount, NV - nl);

    send_word(32'hF, 4, 1'b1, 1'b1);
    chk("R5 no change no update", {lv, rv}, 0);
    @(negedge bclk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset words", {lw, rw}, 0);
    @(negedge bclk);
    rst_n = 1'b1;
    send_word(32'hABCD, 16, 1'b1, 1'b0);
    chk("R7 discard after reset strobes", {lv, rv}, 0);
    chk("R7 discard after reset words", {lw, rw}, 0);
    send_word(32'h8001, 16, 1'b0, 1'b1);
    chk("R2 left after reset", lw, 16'h8001);
    chk("R8 variants agree final", {lw2, rw2}, {lw, rw});

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule